// File: doc/BRIEF.md
# Exception and Privilege Control Unit

This block holds the exception state of a 32-bit RISC core. Each cycle the pipeline presents one instruction in its exception-check stage, with its own PC, the PC that would follow it, any data address it uses, and a set of fault flags. The six external interrupt lines come in too. When something must be taken, the block picks one cause by a fixed priority. In the same cycle it asks the front end to fetch from the handler vector. At the next clock edge it records the return address, the cause code and, for address faults, the offending address. It also switches the core into kernel mode.

The block keeps a status word with the privilege bit, a global interrupt enable, an exception-state bit and one mask bit per interrupt line. Software reads and writes the control registers through a move-to/move-from port. In user mode it may not use those moves, nor touch the upper half of the address space. A return request sends fetch back to the saved address and drops the core to user mode.

Top module: `exc_ctrl`

## Requirements
- R1: When an exception is taken (`exc_o` high), `redirect_o` is high and `redirect_pc_o` is 0x80000180 in that same cycle. After the next clock edge `kernel_o` is 1 and status bit 1 (exception state) is 1.
- R2: For bus errors, address errors and reserved-instruction faults, the saved return address (register 14) becomes `pc_i`. For every other cause it becomes `next_pc_i`.
- R3: Register 8 is loaded only when an address error is taken. It gets `pc_i` for a fetch fault and `mem_addr_i` for a data fault. All other causes leave it unchanged.
- R4: Bits 6:2 of register 13 hold the cause code. The codes are: interrupt 0, address error on fetch or load 4, address error on store 5, fetch bus error 6, data bus error 7, syscall 8, break 9, reserved instruction 10, overflow 12, trap 13, floating point 15. Bits 13:8 of register 13 show `irq_i` live.
- R5: When several causes are present in one cycle, the order is: fetch bus error, data bus error, fetch address error, data address error (`misalign_i`, or a user-mode data access to the upper half), reserved instruction, overflow, syscall, break, trap, floating point, and interrupt last.
- R6: In user mode, a fetch with `pc_i` bit 31 set is an address error. So is a data access (`mem_acc_i`) with `mem_addr_i` bit 31 set. Address 0x7FFFFFFC raises nothing. In kernel mode, upper-half addresses raise nothing.
- R7: In user mode, `mtc0_i` or `mfc0_i` raises a reserved-instruction fault, and no control register is written.
- R8: An interrupt is taken only when status bit 0 (global enable) is 1, status bit 1 (exception state) is 0, and line k is high with status bit 8+k set. It records code 0.
- R9: Register 12 is the status word: bit 0 enable, bit 1 exception state, bit 2 kernel mode, bits 13:8 interrupt masks. Only those bits are writable. Register 14 is writable. Registers 8 and 13 are read-only. `cp0_rdata_o` shows the register selected by `cp0_sel_i` without any strobe, and unmapped numbers read 0. After reset the status word is 0x4, and the other registers read 0.
- R10: A kernel-mode or user-mode `eret_i` with no exception drives `redirect_o` high with `redirect_pc_o` equal to register 14. After the edge, status bits 2 and 1 are cleared.
- R11: While `valid_i` is low, nothing is taken and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | An instruction occupies the check stage |
| pc_i | input | 32 | Address of that instruction |
| next_pc_i | input | 32 | Address of the instruction that would follow |
| mem_acc_i | input | 1 | The instruction accesses data memory |
| mem_wr_i | input | 1 | The data access is a store |
| mem_addr_i | input | 32 | Data address |
| bus_ferr_i | input | 1 | Bus error on fetch |
| bus_derr_i | input | 1 | Bus error on data access |
| misalign_i | input | 1 | Data address flagged bad by the pipeline |
| undef_i | input | 1 | Undefined opcode |
| ovf_i | input | 1 | Integer overflow |
| syscall_i | input | 1 | System call instruction |
| break_i | input | 1 | Breakpoint instruction |
| trap_i | input | 1 | Trap condition true |
| fpe_i | input | 1 | Floating-point fault |
| irq_i | input | 6 | External interrupt lines |
| mtc0_i | input | 1 | Move to a control register |
| mfc0_i | input | 1 | Move from a control register |
| eret_i | input | 1 | Return from exception |
| cp0_sel_i | input | 5 | Control register number |
| cp0_wdata_i | input | 32 | Write data for a move-to |
| cp0_rdata_o | output | 32 | Selected control register |
| exc_o | output | 1 | An exception is taken this cycle |
| redirect_o | output | 1 | Fetch must restart at `redirect_pc_o` |
| redirect_pc_o | output | 32 | New fetch address |
| kernel_o | output | 1 | Current privilege, 1 = kernel |

## Verification
The bench builds the block with its default parameters: 32-bit words, six interrupt lines and the handler vector at 0x80000180. With these values the upper-half boundary at bit 31 can be probed directly with 0x7FFFFFFC, 0x80000000 and 0x90000000. Every interrupt mask bit sits at a known position 8+k, so a single masked line and a single unmasked line can be told apart. A vector table drives every cause alone and in overlapping groups, so that the priority order and the split of the return address between faulting and next PC are both observed. Directed sequences then cover the privilege changes: return to user mode, faults in user mode, and the status word left intact after a refused write.

// File: rtl/exc_ctrl.sv
module exc_ctrl #(
  parameter int XLEN = 32,
  parameter int NIRQ = 6,
  parameter logic [XLEN-1:0] VECTOR = 32'h8000_0180
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] next_pc_i,
  input  logic            mem_acc_i,
  input  logic            mem_wr_i,
  input  logic [XLEN-1:0] mem_addr_i,
  input  logic            bus_ferr_i,
  input  logic            bus_derr_i,
  input  logic            misalign_i,
  input  logic            undef_i,
  input  logic            ovf_i,
  input  logic            syscall_i,
  input  logic            break_i,
  input  logic            trap_i,
  input  logic            fpe_i,
  input  logic [NIRQ-1:0] irq_i,
  input  logic            mtc0_i,
  input  logic            mfc0_i,
  input  logic            eret_i,
  input  logic [4:0]      cp0_sel_i,
  input  logic [XLEN-1:0] cp0_wdata_i,
  output logic [XLEN-1:0] cp0_rdata_o,
  output logic            exc_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            kernel_o
);

  localparam int IE  = 0;
  localparam int EXL = 1;
  localparam int KM  = 2;
  localparam int IM  = 8;
  localparam logic [4:0] SEL_BADV   = 5'd8;
  localparam logic [4:0] SEL_STATUS = 5'd12;
  localparam logic [4:0] SEL_CAUSE  = 5'd13;
  localparam logic [4:0] SEL_EPC    = 5'd14;
  localparam logic [XLEN-1:0] WMASK =
    (XLEN'({NIRQ{1'b1}}) << IM) | XLEN'(7);
  localparam logic [XLEN-1:0] STATUS_RST = XLEN'(1) << KM;

  logic [XLEN-1:0] status_q, epc_q, badv_q;
  logic [4:0]      code_q;

  logic            take, precise, set_bad;
  logic [4:0]      code_n;
  logic [XLEN-1:0] bad_n;

  wire user     = !status_q[KM];
  wire fetch_ae = user && pc_i[XLEN-1];
  wire data_ae  = mem_acc_i && (misalign_i || (user && mem_addr_i[XLEN-1]));
  wire ri       = undef_i || (user && (mtc0_i || mfc0_i));
  wire [NIRQ-1:0] irq_hit = irq_i & status_q[IM +: NIRQ];
  wire irq_ok   = status_q[IE] && !status_q[EXL] && (|irq_hit);

  always_comb begin
    take    = valid_i;
    precise = 1'b0;
    set_bad = 1'b0;
    code_n  = 5'd0;
    bad_n   = mem_addr_i;
    if (!valid_i)        take = 1'b0;
    else if (bus_ferr_i) begin code_n = 5'd6; precise = 1'b1; end
    else if (bus_derr_i) begin code_n = 5'd7; precise = 1'b1; end
    else if (fetch_ae) begin
      code_n = 5'd4; precise = 1'b1; set_bad = 1'b1; bad_n = pc_i;
    end
    else if (data_ae) begin
      code_n = mem_wr_i ? 5'd5 : 5'd4; precise = 1'b1; set_bad = 1'b1;
    end
    else if (ri)         begin code_n = 5'd10; precise = 1'b1; end
    else if (ovf_i)      code_n = 5'd12;
    else if (syscall_i)  code_n = 5'd8;
    else if (break_i)    code_n = 5'd9;
    else if (trap_i)     code_n = 5'd13;
    else if (fpe_i)      code_n = 5'd15;
    else if (irq_ok)     code_n = 5'd0;
    else                 take = 1'b0;
  end

  wire eret_go = valid_i && eret_i && !take;
  wire wr_ok   = valid_i && mtc0_i && !take;

  assign exc_o         = take;
  assign redirect_o    = take || eret_go;
  assign redirect_pc_o = take ? VECTOR : epc_q;
  assign kernel_o      = status_q[KM];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= STATUS_RST;
      epc_q    <= '0;
      badv_q   <= '0;
      code_q   <= '0;
    end else if (take) begin
      status_q[KM]  <= 1'b1;
      status_q[EXL] <= 1'b1;
      epc_q         <= precise ? pc_i : next_pc_i;
      code_q        <= code_n;
      if (set_bad) badv_q <= bad_n;
    end else if (eret_go) begin
      status_q[KM]  <= 1'b0;
      status_q[EXL] <= 1'b0;
    end else if (wr_ok) begin
      if (cp0_sel_i == SEL_STATUS) status_q <= cp0_wdata_i & WMASK;
      if (cp0_sel_i == SEL_EPC)    epc_q    <= cp0_wdata_i;
    end
  end

  logic [XLEN-1:0] cause_v;
  always_comb begin
    cause_v = '0;
    cause_v[6:2] = code_q;
    cause_v[IM +: NIRQ] = irq_i;
  end

  always_comb begin
    case (cp0_sel_i)
      SEL_BADV:   cp0_rdata_o = badv_q;
      SEL_STATUS: cp0_rdata_o = status_q;
      SEL_CAUSE:  cp0_rdata_o = cause_v;
      SEL_EPC:    cp0_rdata_o = epc_q;
      default:    cp0_rdata_o = '0;
    endcase
  end

  a_r1_enter_kernel: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o |=> (kernel_o && status_q[EXL]));

  a_r2_bus_epc: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_o && (bus_ferr_i || bus_derr_i)) |=> (epc_q == $past(pc_i)));

  a_r7_user_move: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !kernel_o && (mtc0_i || mfc0_i)) |-> exc_o);

  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_o && (!status_q[IE] || status_q[EXL])) |-> (code_n != 5'd0));

  a_r10_eret_user: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && eret_i && !exc_o) |=> !kernel_o);

  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(status_q) && $stable(epc_q) && $stable(badv_q)));

endmodule

// File: tb/exc_ctrl_tb.sv
module exc_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VEC = 32'h8000_0180;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid_i, mem_acc_i, mem_wr_i;
  logic bus_ferr_i, bus_derr_i, misalign_i, undef_i, ovf_i;
  logic syscall_i, break_i, trap_i, fpe_i, mtc0_i, mfc0_i, eret_i;
  logic [31:0] pc_i, next_pc_i, mem_addr_i, cp0_wdata_i, cp0_rdata_o, redirect_pc_o;
  logic [5:0]  irq_i;
  logic [4:0]  cp0_sel_i;
  logic exc_o, redirect_o, kernel_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] v, exp_bad;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .pc_i(pc_i), .next_pc_i(next_pc_i),
    .mem_acc_i(mem_acc_i), .mem_wr_i(mem_wr_i), .mem_addr_i(mem_addr_i),
    .bus_ferr_i(bus_ferr_i), .bus_derr_i(bus_derr_i), .misalign_i(misalign_i),
    .undef_i(undef_i), .ovf_i(ovf_i), .syscall_i(syscall_i), .break_i(break_i),
    .trap_i(trap_i), .fpe_i(fpe_i), .irq_i(irq_i), .mtc0_i(mtc0_i), .mfc0_i(mfc0_i),
    .eret_i(eret_i), .cp0_sel_i(cp0_sel_i), .cp0_wdata_i(cp0_wdata_i),
    .cp0_rdata_o(cp0_rdata_o), .exc_o(exc_o), .redirect_o(redirect_o),
    .redirect_pc_o(redirect_pc_o), .kernel_o(kernel_o));

  typedef struct packed {
    logic [8:0]  req;   // {fpe,trap,break,syscall,ovf,undef,misalign,bus_derr,bus_ferr}
    logic        acc;
    logic        wr;
    logic [31:0] addr;
    logic [4:0]  code;
    logic        prec;
    logic        bad;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{9'b000000001, 1'b0, 1'b0, 32'h0,         5'd6,  1'b1, 1'b0},
    '{9'b000000010, 1'b1, 1'b0, 32'h1000_0000, 5'd7,  1'b1, 1'b0},
    '{9'b000000100, 1'b1, 1'b0, 32'h1000_0002, 5'd4,  1'b1, 1'b1},
    '{9'b000000100, 1'b1, 1'b1, 32'h1000_0005, 5'd5,  1'b1, 1'b1},
    '{9'b000001000, 1'b0, 1'b0, 32'h0,         5'd10, 1'b1, 1'b0},
    '{9'b000010000, 1'b0, 1'b0, 32'h0,         5'd12, 1'b0, 1'b0},
    '{9'b000100000, 1'b0, 1'b0, 32'h0,         5'd8,  1'b0, 1'b0},
    '{9'b001000000, 1'b0, 1'b0, 32'h0,         5'd9,  1'b0, 1'b0},
    '{9'b010000000, 1'b0, 1'b0, 32'h0,         5'd13, 1'b0, 1'b0},
    '{9'b100000000, 1'b0, 1'b0, 32'h0,         5'd15, 1'b0, 1'b0},
    '{9'b000010010, 1'b1, 1'b0, 32'h1000_0010, 5'd7,  1'b1, 1'b0},
    '{9'b000101100, 1'b1, 1'b1, 32'h2000_0003, 5'd5,  1'b1, 1'b1},
    '{9'b100001000, 1'b0, 1'b0, 32'h0,         5'd10, 1'b1, 1'b0},
    '{9'b010100000, 1'b0, 1'b0, 32'h0,         5'd8,  1'b0, 1'b0},
    '{9'b000000101, 1'b1, 1'b0, 32'h3000_0001, 5'd6,  1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    valid_i = 0; mem_acc_i = 0; mem_wr_i = 0; mem_addr_i = 0;
    bus_ferr_i = 0; bus_derr_i = 0; misalign_i = 0; undef_i = 0; ovf_i = 0;
    syscall_i = 0; break_i = 0; trap_i = 0; fpe_i = 0; irq_i = 0;
    mtc0_i = 0; mfc0_i = 0; eret_i = 0; cp0_sel_i = 0; cp0_wdata_i = 0;
    pc_i = 32'h0040_0000; next_pc_i = 32'h0040_0004;
  endtask

  task automatic rd(input logic [4:0] sel, output logic [31:0] val);
    cp0_sel_i = sel; #1 val = cp0_rdata_o;
  endtask

  task automatic wr(input logic [4:0] sel, input logic [31:0] d);
    @(negedge clk); idle(); valid_i = 1; mtc0_i = 1; cp0_sel_i = sel; cp0_wdata_i = d;
    @(posedge clk); #1 idle();
  endtask

  task automatic set_pc(input logic [31:0] p);
    pc_i = p; next_pc_i = p + 4;
  endtask

  task automatic go_user();
    wr(5'd14, 32'h0040_0000);
    @(negedge clk); idle(); valid_i = 1; eret_i = 1;
    @(posedge clk); #1 idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk("R9 reset kernel", {31'b0, kernel_o}, 32'h1);
    chk("R9 reset redirect", {31'b0, redirect_o}, 32'h0);
    rd(5'd12, v); chk("R9 reset status", v, 32'h4);
    rd(5'd14, v); chk("R9 reset epc", v, 32'h0);
    rd(5'd13, v); chk("R9 reset cause", v, 32'h0);
    rd(5'd5, v);  chk("R9 unmapped", v, 32'h0);

    // R11 no valid
    @(negedge clk); idle(); syscall_i = 1; set_pc(32'h0040_0040); #1;
    chk("R11 no redirect", {31'b0, redirect_o}, 32'h0);
    @(posedge clk); #1 idle();
    rd(5'd14, v); chk("R11 epc kept", v, 32'h0);

    // R8 interrupts
    wr(5'd12, 32'h0000_0405);
    rd(5'd12, v); chk("R9 status write", v, 32'h405);
    @(negedge clk); idle(); valid_i = 1; irq_i = 6'b000010; #1;
    chk("R8 masked line", {31'b0, redirect_o}, 32'h0);
    rd(5'd13, v); chk("R4 pending field", v[13:8], 32'h2);
    @(posedge clk); #1 idle();
    @(negedge clk); idle(); valid_i = 1; irq_i = 6'b000100; set_pc(32'h0040_0080); #1;
    chk("R8 irq taken", {31'b0, exc_o}, 32'h1);
    chk("R1 vector", redirect_pc_o, VEC);
    @(posedge clk); #1 idle();
    rd(5'd13, v); chk("R4 irq code", {27'b0, v[6:2]}, 32'd0);
    rd(5'd14, v); chk("R8 epc next", v, 32'h0040_0084);
    @(negedge clk); idle(); valid_i = 1; irq_i = 6'b000100; #1;
    chk("R8 exl blocks", {31'b0, redirect_o}, 32'h0);
    @(posedge clk); #1 idle();
    wr(5'd12, 32'h0000_0404);
    @(negedge clk); idle(); valid_i = 1; irq_i = 6'b000100; #1;
    chk("R8 ie off blocks", {31'b0, redirect_o}, 32'h0);
    @(posedge clk); #1 idle();

    // R1-style table: R2 R3 R4 R5
    exp_bad = 32'h0;
    for (int i = 0; i < NV; i++) begin
      logic [31:0] p;
      p = 32'h0040_1000 + 32'(i) * 16;
      @(negedge clk); idle(); valid_i = 1; set_pc(p);
      {fpe_i, trap_i, break_i, syscall_i, ovf_i, undef_i, misalign_i, bus_derr_i, bus_ferr_i} = TBL[i].req;
      mem_acc_i = TBL[i].acc; mem_wr_i = TBL[i].wr; mem_addr_i = TBL[i].addr; #1;
      chk($sformatf("R1 redirect v%0d", i), {31'b0, redirect_o}, 32'h1);
      chk($sformatf("R1 vector v%0d", i), redirect_pc_o, VEC);
      @(posedge clk); #1 idle();
      if (TBL[i].bad) exp_bad = TBL[i].addr;
      chk($sformatf("R1 kernel v%0d", i), {31'b0, kernel_o}, 32'h1);
      rd(5'd13, v); chk($sformatf("R4 R5 code v%0d", i), {27'b0, v[6:2]}, {27'b0, TBL[i].code});
      rd(5'd14, v); chk($sformatf("R2 epc v%0d", i), v, TBL[i].prec ? p : p + 4);
      rd(5'd8, v);  chk($sformatf("R3 badvaddr v%0d", i), v, exp_bad);
    end

    // R10 return
    wr(5'd12, 32'h0000_0405);
    wr(5'd14, 32'h0040_0200);
    @(negedge clk); idle(); valid_i = 1; eret_i = 1; #1;
    chk("R10 redirect", {31'b0, redirect_o}, 32'h1);
    chk("R10 target", redirect_pc_o, 32'h0040_0200);
    @(posedge clk); #1 idle();
    chk("R10 user", {31'b0, kernel_o}, 32'h0);
    rd(5'd12, v); chk("R10 status", v, 32'h401);

    // R6 user boundary
    @(negedge clk); idle(); valid_i = 1; set_pc(32'h0040_0300);
    mem_acc_i = 1; mem_addr_i = 32'h7FFF_FFFC; #1;
    chk("R6 below boundary", {31'b0, redirect_o}, 32'h0);
    @(posedge clk); #1 idle();

    // R6 user fetch from upper half
    @(negedge clk); idle(); valid_i = 1; set_pc(32'h8000_1000); #1;
    chk("R6 fetch fault", {31'b0, exc_o}, 32'h1);
    @(posedge clk); #1 idle();
    rd(5'd13, v); chk("R6 fetch code", {27'b0, v[6:2]}, 32'd4);
    rd(5'd8, v);  chk("R3 fetch bad", v, 32'h8000_1000);
    rd(5'd14, v); chk("R2 fetch epc", v, 32'h8000_1000);

    // R6 user store to upper half
    go_user();
    @(negedge clk); idle(); valid_i = 1; set_pc(32'h0040_0400);
    mem_acc_i = 1; mem_wr_i = 1; mem_addr_i = 32'h9000_0000; #1;
    chk("R6 store fault", {31'b0, exc_o}, 32'h1);
    @(posedge clk); #1 idle();
    rd(5'd13, v); chk("R6 store code", {27'b0, v[6:2]}, 32'd5);
    rd(5'd8, v);  chk("R3 store bad", v, 32'h9000_0000);

    // R7 user move-to
    go_user();
    @(negedge clk); idle(); valid_i = 1; set_pc(32'h0040_0500);
    mtc0_i = 1; cp0_sel_i = 5'd12; cp0_wdata_i = 32'h0; #1;
    chk("R7 mtc0 fault", {31'b0, exc_o}, 32'h1);
    @(posedge clk); #1 idle();
    rd(5'd13, v); chk("R7 mtc0 code", {27'b0, v[6:2]}, 32'd10);
    rd(5'd12, v); chk("R7 status intact", v, 32'h407);
    rd(5'd14, v); chk("R7 epc faulting", v, 32'h0040_0500);

    // R7 user move-from
    go_user();
    @(negedge clk); idle(); valid_i = 1; set_pc(32'h0040_0600); mfc0_i = 1; cp0_sel_i = 5'd13; #1;
    chk("R7 mfc0 fault", {31'b0, exc_o}, 32'h1);
    @(posedge clk); #1 idle();
    rd(5'd13, v); chk("R7 mfc0 code", {27'b0, v[6:2]}, 32'd10);

    // R6 kernel upper half allowed
    @(negedge clk); idle(); valid_i = 1; set_pc(32'h8000_2000);
    mem_acc_i = 1; mem_addr_i = 32'h8000_0000; #1;
    chk("R6 kernel ok", {31'b0, redirect_o}, 32'h0);
    @(posedge clk); #1 idle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule